// File: doc/BRIEF.md
# Publish-Subscribe Event Channel Fabric

This block connects single-cycle event pulses from many sources to single-cycle task pulses on many sinks, with no processor in the path. Routing is held at each endpoint, not in a table per channel. Every event source owns a publish entry that names one channel and carries a connect bit. Every task sink owns a subscribe entry of the same shape. Any number of sources may drive one channel, and any number of sinks may listen to it. Adding a consumer only means pointing one more subscribe entry at the channel.

A channel carries nothing until it is switched on in a central enable vector. That vector is changed through write-one-to-set and write-one-to-clear locations, and a status location reads it back. A small register port programs all entries. Writes take effect at the next clock edge. Reads are combinational. The task outputs are registered, so an event sampled at one rising edge appears on its tasks right after that edge and lasts one cycle.

Register map, using byte-free word addresses on `wr_addr`/`rd_addr`:
- 0x00: set channel enables. Each 1 bit in `wr_data[N_CH-1:0]` sets that channel.
- 0x01: clear channel enables. Each 1 bit clears that channel.
- 0x02: status. Reads the enable vector in bits `[N_CH-1:0]`.
- 0x40+i: publish entry of event i.
- 0x80+j: subscribe entry of task j.

An entry holds the channel number in bits `[CW-1:0]`, where CW = log2(N_CH), and the connect bit in bit CW. The entry is stored as `wr_data[CW:0]` and reads back zero-extended.

Top module: `evt_route_fabric`

## Requirements
- R1: After reset every task output is 0, the channel status reads 0, and every publish and subscribe entry reads 0.
- R2: An event pulse sampled at a rising edge, published to an enabled channel that a connected task subscribes to, drives that task high for exactly the following cycle.
- R3: A channel whose enable bit is 0 passes no event to its subscribers.
- R4: A publish entry whose connect bit (bit CW) is 0 contributes nothing, whatever channel number it holds.
- R5: A subscribe entry whose connect bit (bit CW) is 0 never fires its task, whatever channel number it holds.
- R6: When several connected events publish to one channel in the same cycle, each subscriber gives one single-cycle pulse, as it does for one event.
- R7: All connected tasks subscribed to an active channel fire in the same cycle.
- R8: A write to 0x00 ORs `wr_data` into the enable vector. A write to 0x01 clears the bits set in `wr_data`. Bits not named keep their value. Status at 0x02 shows the vector after the write.
- R9: A publish or subscribe entry reads back `wr_data[CW:0]` of its last write, with all higher bits 0.
- R10: An event on one channel never fires a task subscribed only to a different channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Combinational read data |
| evt_i | input | N_EVT | Event pulses, one per source |
| task_o | output | N_TSK | Registered task pulses, one per sink |

## Verification
Some rules hold on every cycle, and the assertions check those. They are: quiet task outputs in and after reset, no task pulse without an event the cycle before, no task pulse while every channel is off, and the set, clear and hold arithmetic of the enable vector.

Other behaviours depend on how the entries are programmed, so only the bench scenarios can show them. These are fan-in, fan-out, the effect of each connect bit, isolation between channels, and entry readback. A scoreboard predicts every task vector from its own model of the entries and enables, then compares it with the design cycle by cycle.

// File: rtl/evt_route_fabric.sv
module evt_route_fabric #(
  parameter int N_EVT = 8,
  parameter int N_TSK = 8,
  parameter int N_CH  = 16,
  parameter int AW    = 8,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    rd_data,
  input  logic [N_EVT-1:0] evt_i,
  output logic [N_TSK-1:0] task_o
);
  localparam int CW       = $clog2(N_CH);
  localparam int A_SET    = 'h00;
  localparam int A_CLR    = 'h01;
  localparam int A_STAT   = 'h02;
  localparam int PUB_BASE = 'h40;
  localparam int SUB_BASE = 'h80;

  logic [N_CH-1:0]        ch_en_q;
  logic [N_EVT-1:0][CW:0] pub_q;
  logic [N_TSK-1:0][CW:0] sub_q;
  logic [N_CH-1:0]        ch_hit, ch_act;
  logic [N_TSK-1:0]       task_d;

  always_ff @(posedge clk) begin
    if (rst) ch_en_q <= '0;
    else if (wr_en && wr_addr == AW'(A_SET)) ch_en_q <= ch_en_q | wr_data[N_CH-1:0];
    else if (wr_en && wr_addr == AW'(A_CLR)) ch_en_q <= ch_en_q & ~wr_data[N_CH-1:0];
  end

  for (genvar i = 0; i < N_EVT; i++) begin : g_pub
    always_ff @(posedge clk) begin
      if (rst) pub_q[i] <= '0;
      else if (wr_en && wr_addr == AW'(PUB_BASE + i)) pub_q[i] <= wr_data[CW:0];
    end
  end

  for (genvar j = 0; j < N_TSK; j++) begin : g_sub
    always_ff @(posedge clk) begin
      if (rst) sub_q[j] <= '0;
      else if (wr_en && wr_addr == AW'(SUB_BASE + j)) sub_q[j] <= wr_data[CW:0];
    end
    assign task_d[j] = sub_q[j][CW] & ch_act[sub_q[j][CW-1:0]];
  end

  always_comb begin
    ch_hit = '0;
    for (int c = 0; c < N_CH; c++)
      for (int e = 0; e < N_EVT; e++)
        if (evt_i[e] && pub_q[e][CW] && pub_q[e][CW-1:0] == CW'(c)) ch_hit[c] = 1'b1;
  end

  assign ch_act = ch_hit & ch_en_q;

  always_ff @(posedge clk) begin
    if (rst) task_o <= '0;
    else     task_o <= task_d;
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == AW'(A_STAT)) rd_data = DW'(ch_en_q);
    for (int i = 0; i < N_EVT; i++)
      if (rd_addr == AW'(PUB_BASE + i)) rd_data = DW'(pub_q[i]);
    for (int j = 0; j < N_TSK; j++)
      if (rd_addr == AW'(SUB_BASE + j)) rd_data = DW'(sub_q[j]);
  end
endmodule

// File: rtl/evt_route_fabric_chk.sv
module evt_route_fabric_chk #(
  parameter int N_EVT = 8,
  parameter int N_TSK = 8,
  parameter int N_CH  = 16,
  parameter int AW    = 8,
  parameter int DW    = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [AW-1:0]    wr_addr,
  input logic [DW-1:0]    wr_data,
  input logic [N_EVT-1:0] evt_i,
  input logic [N_TSK-1:0] task_o,
  input logic [N_CH-1:0]  ch_en_q
);
  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> task_o == '0);
  a_r1_reset_status: assert property (@(posedge clk) rst |=> ch_en_q == '0);

  a_r2_no_spurious_task: assert property (@(posedge clk) disable iff (rst)
    evt_i == '0 |=> task_o == '0);

  a_r3_all_off_silent: assert property (@(posedge clk) disable iff (rst)
    ch_en_q == '0 |=> task_o == '0);

  a_r8_set_or: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == AW'(0)) |=> ch_en_q == ($past(ch_en_q) | $past(wr_data[N_CH-1:0])));

  a_r8_clear_mask: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == AW'(1)) |=> ch_en_q == ($past(ch_en_q) & ~$past(wr_data[N_CH-1:0])));

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(ch_en_q));
endmodule

bind evt_route_fabric evt_route_fabric_chk #(
  .N_EVT(N_EVT), .N_TSK(N_TSK), .N_CH(N_CH), .AW(AW), .DW(DW)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .evt_i(evt_i), .task_o(task_o), .ch_en_q(ch_en_q)
);

// File: tb/evt_route_fabric_test.sv
module evt_route_fabric_test;
  localparam int N_EVT = 8, N_TSK = 8, N_CH = 16, AW = 8, DW = 32;
  localparam int CW = $clog2(N_CH);

  logic clk = 0, rst = 1, wr_en = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0, rd_data;
  logic [N_EVT-1:0] evt_i = '0;
  logic [N_TSK-1:0] task_o;

  evt_route_fabric #(.N_EVT(N_EVT), .N_TSK(N_TSK), .N_CH(N_CH), .AW(AW), .DW(DW)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .evt_i(evt_i), .task_o(task_o));

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [N_TSK-1:0] exp_q[$];
  string tag_q[$];

  logic [CW:0] m_pub[N_EVT];
  logic [CW:0] m_sub[N_TSK];
  logic [N_CH-1:0] m_en;

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [N_TSK-1:0] predict(logic [N_EVT-1:0] v);
    logic [N_TSK-1:0] r = '0;
    for (int t = 0; t < N_TSK; t++) begin
      if (m_sub[t][CW] && m_en[m_sub[t][CW-1:0]])
        for (int e = 0; e < N_EVT; e++)
          if (v[e] && m_pub[e][CW] && m_pub[e][CW-1:0] == m_sub[t][CW-1:0]) r[t] = 1'b1;
    end
    return r;
  endfunction

  task automatic wr(int addr, logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = AW'(addr); wr_data = d;
    if (addr == 0) m_en = m_en | d[N_CH-1:0];
    else if (addr == 1) m_en = m_en & ~d[N_CH-1:0];
    else if (addr >= 'h80) m_sub[addr - 'h80] = d[CW:0];
    else if (addr >= 'h40) m_pub[addr - 'h40] = d[CW:0];
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd_check(string tag, int addr, logic [DW-1:0] exp);
    @(negedge clk);
    rd_addr = AW'(addr);
    #1 check(tag, rd_data, exp);
  endtask

  task automatic fire(string tag, logic [N_EVT-1:0] v);
    @(negedge clk);
    evt_i = v;
    exp_q.push_back(predict(v)); tag_q.push_back(tag);
    @(negedge clk);
    evt_i = '0;
    exp_q.push_back('0); tag_q.push_back({tag, "_idle"});
  endtask

  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) check(tag_q.pop_front(), DW'(task_o), DW'(exp_q.pop_front()));
  end

  localparam logic [DW-1:0] ON = DW'(1) << CW;

  initial begin
    m_en = '0;
    for (int i = 0; i < N_EVT; i++) m_pub[i] = '0;
    for (int i = 0; i < N_TSK; i++) m_sub[i] = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    #1 check("R1 task_o", DW'(task_o), '0);
    rd_check("R1 status", 2, '0);
    rd_check("R1 pub0", 'h40, '0);
    rd_check("R1 sub0", 'h80, '0);

    wr('h40, ON | 3); wr('h80, ON | 3);
    fire("R3 channel_off", 8'h01);
    check("R3 model_zero", DW'(predict(8'h01)), '0);

    wr(0, 32'h8);
    rd_check("R8 status_set", 2, 32'h8);
    fire("R2 single", 8'h01);

    wr('h81, ON | 3); wr('h82, ON | 3);
    fire("R7 fanout", 8'h01);

    wr('h41, ON | 3); wr('h42, ON | 3);
    fire("R6 fanin", 8'h07);

    wr('h40, 3);
    fire("R4 pub_disconnected", 8'h01);
    rd_check("R9 pub_readback", 'h40, 32'h3);

    wr('h81, 3);
    fire("R5 sub_disconnected", 8'h02);

    wr('h43, ON | 5); wr('h83, ON | 5); wr(0, 32'h20);
    rd_check("R8 status_keep", 2, 32'h28);
    fire("R10 isolated", 8'h08);
    fire("R10 mixed", 8'h0A);

    wr(1, 32'h8);
    rd_check("R8 status_clear", 2, 32'h20);
    fire("R3 after_clear", 8'h02);
    fire("R2 ch5_live", 8'h08);

    wr('h84, 32'hFFFF_FFFF);
    rd_check("R9 sub_width", 'h84, 32'h1F);
    fire("R10 ch15_silent", 8'h08);

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule